// File: doc/BRIEF.md
# Set/Reset PWM Waveform Generator

This block produces a pulse-width-modulated square wave from a time-base clock that has already been divided down. A free-running counter is compared against two captured parameters. A match with the period parameter ends the cycle and starts the next one. A match with the width parameter turns the output off. A small 2-bit state machine sequences these events in the way a set/reset latch would. A single-cycle start/stop pulse switches the block between an idle state, where the output is held low, and continuous generation.

The period of the output is `wp + 2` clocks and its high time is `pw + 1` clocks. When `pw` exceeds `wp` the duty cycle is 100 %. Both parameters are sampled only when a period begins, so every period is generated whole, with a single pair of values. The block also drives an inverted copy of the waveform for loads that are active low.

Top module: `pwm_gen`

## Requirements
- R1: After reset the block is idle: `pwm` is 0 and `pwm_n` is 1, and this holds until a start pulse arrives.
- R2: A `st` pulse sampled while idle starts generation. `pwm` is 1 in the cycle that follows that clock edge, which is the first cycle of a period.
- R3: While running, each period lasts exactly `wp + 2` clock cycles, counted from the first high cycle. This holds for every `wp` from 0 up to the all-ones value.
- R4: When `pw <= wp`, `pwm` is 1 for the first `pw + 1` cycles of each period and 0 for the remaining `wp - pw + 1` cycles.
- R5: When `pw > wp`, `pwm` stays at 1 for every cycle of every period (100 % duty).
- R6: A `st` pulse sampled while running stops generation. `pwm` is 0 from the next cycle and stays 0 until another `st` pulse. The following start begins a fresh period.
- R7: `pw` and `wp` are captured only when a period begins, either at a start or at a period boundary. A change during a period first affects the next period.
- R8: `pwm_n` is always the logical complement of `pwm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock (already divided) |
| rst | input | 1 | Synchronous reset, active high |
| st | input | 1 | Single-cycle start/stop toggle pulse |
| pw | input | W | Pulse-width parameter; the high time is pw+1 clocks |
| wp | input | W | Period parameter; the period is wp+2 clocks |
| pwm | output | 1 | PWM output, active high |
| pwm_n | output | 1 | Inverted PWM output |

## Verification
On every cycle the assertions check the local sequencing rules. These are: the counter returns to zero after a period match, the parameter registers stay stable inside a period, the output is low in the low phase and high when the duty is full, and start and stop each take effect one edge later. Only the bench scenarios can show the actual waveform shapes, that is, the exact high count and period length over whole periods. The bench sweeps every `pw`/`wp` pair of a 4-bit instance and uses several 10-bit corner points. It also shows the effect of a parameter change in the middle of a period, and that a restart after a stop begins a clean period.

// File: rtl/pwm_gen.sv
module pwm_gen #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         st,
  input  logic [W-1:0] pw,
  input  logic [W-1:0] wp,
  output logic         pwm,
  output logic         pwm_n
);

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_HIGH = 2'b01,
    S_LOW  = 2'b10,
    S_TAIL = 2'b11
  } state_t;

  state_t       state;
  logic [W-1:0] cnt, pw_r, wp_r;

  wire run  = (state != S_IDLE);
  wire ws   = (state == S_HIGH || state == S_LOW) && (cnt == wp_r);
  wire wr   = (state == S_HIGH) && (cnt == pw_r);
  wire load = (state == S_IDLE && st) || (state == S_TAIL && !st);
  wire full = (pw_r > wp_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      pw_r  <= '0;
      wp_r  <= '0;
    end else begin
      if (load) begin
        pw_r <= pw;
        wp_r <= wp;
      end
      if (run && st) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          S_IDLE: if (st) begin
            state <= S_HIGH;
            cnt   <= '0;
          end
          S_HIGH: if (ws) begin
            state <= S_TAIL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
            if (wr) state <= S_LOW;
          end
          S_LOW: if (ws) begin
            state <= S_TAIL;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: state <= S_HIGH;
        endcase
      end
    end
  end

  assign pwm   = (state == S_HIGH) || (state == S_TAIL && full);
  assign pwm_n = ~pwm;

  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && st) |=> pwm); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ws && !st) |=> (cnt == '0)); // R3
  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOW) |-> (cnt > pw_r && !pwm)); // R4
  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
    (state == S_HIGH && full && !st) |=> pwm); // R5
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
    (run && st) |=> (!pwm && cnt == '0)); // R6
  AST_PARAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((state == S_HIGH || state == S_LOW) && !st) |=> ($stable(pw_r) && $stable(wp_r))); // R7

endmodule

// File: tb/pwm_gen_bench.sv
module pwm_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st  = 1'b0;
  logic [9:0] pw10 = '0, wp10 = '0;
  logic [3:0] pw4 = '0, wp4 = '0;
  logic pwm10, pwm10_n, pwm4, pwm4_n;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  pwm_gen u_pwm_gen (
    .clk(clk), .rst(rst), .st(st), .pw(pw10), .wp(wp10),
    .pwm(pwm10), .pwm_n(pwm10_n)
  );

  pwm_gen #(.W(4)) u_pwm_gen_w4 (
    .clk(clk), .rst(rst), .st(st), .pw(pw4), .wp(wp4),
    .pwm(pwm4), .pwm_n(pwm4_n)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      finish_run();
    end
  end

  function automatic bit model(int i, int p, int w);
    return (i % (w + 2)) <= p;
  endfunction

  task automatic pulse();
    st = 1'b1;
    @(negedge clk);
    st = 1'b0;
  endtask

  // sample n cycles starting at index base; sel=1 -> 10-bit instance
  task automatic expect_run(bit sel, int p, int w, int base, int n, string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      logic o, on;
      bit e;
      o  = sel ? pwm10 : pwm4;
      on = sel ? pwm10_n : pwm4_n;
      e  = model(base + i, p, w);
      if (!bad && (o !== e || on !== ~o)) begin
        bad = 1;
        $display("FAIL %s pw=%0d wp=%0d idx=%0d: actual pwm=%b pwm_n=%b expected pwm=%b pwm_n=%b",
                 req, p, w, base + i, o, on, e, ~e);
      end
      @(negedge clk);
    end
    checks = checks + 1;
    if (bad) failures = failures + 1;
  endtask

  task automatic expect_low(int n, string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!bad && (pwm10 !== 1'b0 || pwm4 !== 1'b0 || pwm10_n !== 1'b1 || pwm4_n !== 1'b1)) begin
        bad = 1;
        $display("FAIL %s idle: actual pwm10=%b pwm4=%b expected 0", req, pwm10, pwm4);
      end
      @(negedge clk);
    end
    checks = checks + 1;
    if (bad) failures = failures + 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_low(8, "R1");

    // R3 R4 R5 R8: exhaustive 4-bit sweep, three periods each
    for (int w = 0; w < 16; w++) begin
      for (int p = 0; p < 16; p++) begin
        pw4 = p[3:0];
        wp4 = w[3:0];
        pulse();
        expect_run(0, p, w, 0, 3 * (w + 2), (p > w) ? "R5" : "R4_R3");
        pulse();
        expect_low(2, "R6");
      end
    end

    // R2 R4: 10-bit nominal point, period 1000, high 250
    pw10 = 10'd249; wp10 = 10'd998;
    pulse();
    expect_run(1, 249, 998, 0, 2000, "R2_R4");
    pulse();
    expect_low(20, "R6");

    // R5: 10-bit full duty
    pw10 = 10'd1023; wp10 = 10'd998;
    pulse();
    expect_run(1, 1023, 998, 0, 1000, "R5");
    pulse();
    expect_low(4, "R6");

    // R3: maximum period with wrap at the counter limit
    pw10 = 10'd0; wp10 = 10'd1023;
    pulse();
    expect_run(1, 0, 1023, 0, 2050, "R3");
    pulse();
    expect_low(4, "R6");

    // R6: stop mid-period, stay low, restart gives a fresh period
    pw4 = 4'd6; wp4 = 4'd12;
    pulse();
    expect_run(0, 6, 12, 0, 3, "R2");
    pulse();
    expect_low(30, "R6");
    pulse();
    expect_run(0, 6, 12, 0, 28, "R6");
    pulse();
    expect_low(2, "R6");

    // R7: changes inside a period take effect at the next boundary
    pw4 = 4'd3; wp4 = 4'd9;
    pulse();
    expect_run(0, 3, 9, 0, 5, "R7");
    pw4 = 4'd12;
    expect_run(0, 3, 9, 5, 6, "R7");
    expect_run(0, 12, 9, 0, 5, "R7");
    pw4 = 4'd1; wp4 = 4'd4;
    expect_run(0, 12, 9, 5, 6, "R7");
    expect_run(0, 1, 4, 0, 18, "R7");
    pulse();
    expect_low(3, "R6");

    finish_run();
  end
endmodule